// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block sits beside the status logic of a 16550-style serial port and decides which pending condition the processor hears about. It keeps the interrupt-enable nibble and a transmit-empty pending flag of its own. Each cycle it takes the live status sources and ranks them with a fixed five-level priority: line errors, character timeout, received data, transmitter empty, and modem change. The result goes into a registered identification byte and a registered interrupt line.

The processor-side register logic drives the enable write, the identification-register read strobe and the data-register write strobe. The transmit path reports when its holding stage or FIFO goes empty and when its FIFO is reset. The receive path supplies data-ready, the trigger-level comparison, the timeout flag and the error flags. Identification-byte bits 7:6 show whether FIFO mode is on.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt line is low, the enable nibble is 0 and the transmit-empty pending flag is clear.
- R2: When several sources are active, the code in identification bits 3:0 is taken from the highest active one. The order, highest first, is: line error 0x6, character timeout 0xC, received data 0x4, transmitter empty 0x2, modem change 0x0. With no active source the code is 0x1.
- R3: A line-error source is active when enable bit 2 is set and any of the four error flags (break, framing, parity, overrun) is set.
- R4: A character-timeout source is active only when enable bit 0 is set and the timeout flag is set.
- R5: A received-data source needs enable bit 0 and data-ready. In FIFO mode it also needs the trigger-reached input.
- R6: Identification bits 7:6 read 11 while FIFO mode is on and 00 otherwise. Bits 5:4 read 0.
- R7: The interrupt line is high exactly when the registered code is not 0x1. Status inputs show up in the byte and on the line one clock edge after they are sampled, and enable writes show up two edges later.
- R8: A read strobe arriving while the byte reports code 0x2 clears the transmit-empty pending flag.
- R9: A write that changes enable bit 1 sets the pending flag to (new bit 1 AND current transmitter-empty status). This takes precedence over every other pending-flag event in the same cycle.
- R10: A data-register write strobe clears the pending flag. A transmitter-became-empty event or a transmit FIFO reset sets it. The clear wins over the set.
- R11: Only enable-write bits 3:0 are stored. Bits 7:4 are ignored.
- R12: A modem-change source needs enable bit 3 and any of the four modem delta flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Enable-register write strobe |
| ierWrData | input | 8 | Enable-register write value |
| dataWrStb | input | 1 | Data-register write strobe |
| iirRdStb | input | 1 | Identification-register read strobe |
| thrEmptyEvt | input | 1 | Transmit holding stage or FIFO just became empty |
| txFifoRst | input | 1 | Transmit FIFO reset strobe |
| threStat | input | 1 | Current transmitter-empty status |
| lsrErr | input | 4 | Break, framing, parity and overrun flags |
| dataReady | input | 1 | Receive data available |
| fifoEn | input | 1 | FIFO mode on |
| trigReached | input | 1 | Receive FIFO count at or above trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | 4 | Modem status delta flags |
| iirByte | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every strobe lasts one cycle. They also assume the read strobe refers to the byte as currently registered, so the transmit-empty clear on read is checked only when no other pending-flag event arrives in the same cycle. The stimulus changes one input or issues one strobe at a time. It then waits long enough for the enable path's two-edge latency before comparing. Because of this, no check depends on how simultaneous events are ordered, except the one precedence that R9 and R10 define.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ENABLE_W = 4;
  localparam int CODE_W   = 4;
  localparam int NUM_SRC  = 5;
  localparam int ERR_W    = 4;
  localparam int DELTA_W  = 4;

  localparam logic [CODE_W-1:0] CODE_NONE    = 4'h1;
  localparam logic [CODE_W-1:0] CODE_LINE    = 4'h6;
  localparam logic [CODE_W-1:0] CODE_TIMEOUT = 4'hC;
  localparam logic [CODE_W-1:0] CODE_RXDATA  = 4'h4;
  localparam logic [CODE_W-1:0] CODE_TXEMPTY = 4'h2;
  localparam logic [CODE_W-1:0] CODE_MODEM   = 4'h0;

  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // control-to-datapath bus
  typedef struct packed {
    logic [ENABLE_W-1:0] ierBits;
    logic                thrPend;
  } ctlBus_t;

  // code for source index, 0 = highest priority
  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      0:       return CODE_LINE;
      1:       return CODE_TIMEOUT;
      2:       return CODE_RXDATA;
      3:       return CODE_TXEMPTY;
      default: return CODE_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ierWrEn,
  input  logic [7:0]        ierWrData,
  input  logic              dataWrStb,
  input  logic              iirRdStb,
  input  logic              thrEmptyEvt,
  input  logic              txFifoRst,
  input  logic              threStat,
  input  logic [CODE_W-1:0] curCode,
  output ctlBus_t           ctl
);
  logic [ENABLE_W-1:0] ierQ;
  logic                thrPendQ;
  logic                thrPendD;
  logic                txEnChange;
  logic                readClr;

  assign txEnChange = ierWrEn && (ierWrData[EN_TX] != ierQ[EN_TX]);
  assign readClr    = iirRdStb && (curCode == CODE_TXEMPTY);

  always_comb begin
    thrPendD = thrPendQ;
    if (txEnChange)
      thrPendD = ierWrData[EN_TX] && threStat;
    else if (dataWrStb)
      thrPendD = 1'b0;
    else if (thrEmptyEvt || txFifoRst)
      thrPendD = 1'b1;
    else if (readClr)
      thrPendD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ     <= '0;
      thrPendQ <= 1'b0;
    end else begin
      if (ierWrEn) ierQ <= ierWrData[ENABLE_W-1:0];
      thrPendQ <= thrPendD;
    end
  end

  assign ctl.ierBits = ierQ;
  assign ctl.thrPend = thrPendQ;

  // R11: only the low nibble lands in the enable register
  assert_ier_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    ierWrEn |=> ierQ == $past(ierWrData[ENABLE_W-1:0]));

  // R9: enable bit 1 change rearms from THRE
  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ierWrEn && (ierWrData[EN_TX] != ierQ[EN_TX]))
      |=> thrPendQ == ($past(ierWrData[EN_TX]) && $past(threStat)));

  // R10: data write clears pending when no enable change
  assert_data_write_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrStb && !ierWrEn) |=> !thrPendQ);

  // R8: read of a transmitter-empty identification clears pending
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (iirRdStb && curCode == CODE_TXEMPTY && !ierWrEn && !dataWrStb
     && !thrEmptyEvt && !txFifoRst) |=> !thrPendQ);
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlBus_t            ctl,
  input  logic [ERR_W-1:0]   lsrErr,
  input  logic               dataReady,
  input  logic               fifoEn,
  input  logic               trigReached,
  input  logic               timeoutPend,
  input  logic [DELTA_W-1:0] modemDelta,
  output logic [7:0]         iirByte,
  output logic               irq
);
  logic [NUM_SRC-1:0] srcHit;
  logic [CODE_W-1:0]  codeD;
  logic [7:0]         iirQ;
  logic               irqQ;
  logic               validQ;

  always_comb begin
    srcHit[0] = ctl.ierBits[EN_LINE]  && (|lsrErr);
    srcHit[1] = ctl.ierBits[EN_RX]    && timeoutPend;
    srcHit[2] = ctl.ierBits[EN_RX]    && dataReady && (!fifoEn || trigReached);
    srcHit[3] = ctl.ierBits[EN_TX]    && ctl.thrPend;
    srcHit[4] = ctl.ierBits[EN_MODEM] && (|modemDelta);
  end

  // lowest-priority first so higher ones overwrite
  always_comb begin
    codeD = CODE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcHit[i]) codeD = srcCode(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iirQ   <= {4'b0000, CODE_NONE};
      irqQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      iirQ   <= {{2{fifoEn}}, 2'b00, codeD};
      irqQ   <= (codeD != CODE_NONE);
      validQ <= 1'b1;
    end
  end

  assign iirByte = iirQ;
  assign irq     = irqQ;

  // R3: enabled line error always wins
  assert_line_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && $past(ctl.ierBits[EN_LINE] && (|lsrErr))) |-> iirByte[3:0] == CODE_LINE);

  // R4: receive enable gates timeout and receive data
  assert_timeout_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !$past(ctl.ierBits[EN_RX]))
      |-> (iirByte[3:0] != CODE_TIMEOUT) && (iirByte[3:0] != CODE_RXDATA));

  // R6: FIFO indication bits follow FIFO mode
  assert_fifo_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (iirByte[7:6] == {2{$past(fifoEn)}}) && (iirByte[5:4] == 2'b00));

  // R7: interrupt line high only with a real code
  assert_irq_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !iirByte[0]);

  // R12: modem code needs modem enable
  assert_modem_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !$past(ctl.ierBits[EN_MODEM])) |-> iirByte[3:0] != CODE_MODEM);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ierWrEn,
  input  logic [7:0] ierWrData,
  input  logic       dataWrStb,
  input  logic       iirRdStb,
  input  logic       thrEmptyEvt,
  input  logic       txFifoRst,
  input  logic       threStat,
  input  logic [3:0] lsrErr,
  input  logic       dataReady,
  input  logic       fifoEn,
  input  logic       trigReached,
  input  logic       timeoutPend,
  input  logic [3:0] modemDelta,
  output logic [7:0] iirByte,
  output logic       irq
);
  ctlBus_t ctlBus;

  uart_irq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ierWrEn     (ierWrEn),
    .ierWrData   (ierWrData),
    .dataWrStb   (dataWrStb),
    .iirRdStb    (iirRdStb),
    .thrEmptyEvt (thrEmptyEvt),
    .txFifoRst   (txFifoRst),
    .threStat    (threStat),
    .curCode     (iirByte[CODE_W-1:0]),
    .ctl         (ctlBus)
  );

  uart_irq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctlBus),
    .lsrErr      (lsrErr),
    .dataReady   (dataReady),
    .fifoEn      (fifoEn),
    .trigReached (trigReached),
    .timeoutPend (timeoutPend),
    .modemDelta  (modemDelta),
    .iirByte     (iirByte),
    .irq         (irq)
  );
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWrEn = 1'b0;
  logic [7:0] ierWrData = '0;
  logic dataWrStb = 1'b0, iirRdStb = 1'b0, thrEmptyEvt = 1'b0, txFifoRst = 1'b0;
  logic threStat = 1'b0;
  logic [3:0] lsrErr = '0;
  logic dataReady = 1'b0, fifoEn = 1'b0, trigReached = 1'b0, timeoutPend = 1'b0;
  logic [3:0] modemDelta = '0;
  logic [7:0] iirByte;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];
  event chk;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData),
    .dataWrStb(dataWrStb), .iirRdStb(iirRdStb), .thrEmptyEvt(thrEmptyEvt),
    .txFifoRst(txFifoRst), .threStat(threStat), .lsrErr(lsrErr),
    .dataReady(dataReady), .fifoEn(fifoEn), .trigReached(trigReached),
    .timeoutPend(timeoutPend), .modemDelta(modemDelta),
    .iirByte(iirByte), .irq(irq)
  );

  // monitor: pops expectations and compares identification byte and irq (R7)
  initial begin
    forever begin
      @(chk);
      while (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (iirByte !== e || irq !== (e[3:0] != 4'h1)) begin
          failures++;
          $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                   t, iirByte, irq, e, (e[3:0] != 4'h1));
        end
      end
    end
  end

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_iir(input logic [7:0] e, input string t);
    settle();
    expQ.push_back(e);
    tagQ.push_back(t);
    ->chk;
    #1;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ierWrData = v; ierWrEn = 1'b1;
    @(negedge clk);
    ierWrEn = 1'b0;
  endtask

  task automatic pulse_data_wr();
    dataWrStb = 1'b1; @(negedge clk); dataWrStb = 1'b0;
  endtask

  task automatic pulse_rd();
    iirRdStb = 1'b1; @(negedge clk); iirRdStb = 1'b0;
  endtask

  task automatic pulse_empty();
    thrEmptyEvt = 1'b1; @(negedge clk); thrEmptyEvt = 1'b0;
  endtask

  task automatic pulse_txrst();
    txFifoRst = 1'b1; @(negedge clk); txFifoRst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expQ.push_back(8'h01); tagQ.push_back("R1 reset state"); ->chk; #1;

    wr_ier(8'h0F);
    expect_iir(8'h01, "R1 nothing pending with all enables");
    modemDelta = 4'b0001;
    expect_iir(8'h00, "R12 modem change");
    threStat = 1'b1; pulse_empty();
    expect_iir(8'h02, "R10 empty event over modem R2");
    dataReady = 1'b1;
    expect_iir(8'h04, "R5 rx data non-fifo R2");
    fifoEn = 1'b1;
    expect_iir(8'hC2, "R5 below trigger R6");
    trigReached = 1'b1;
    expect_iir(8'hC4, "R5 trigger reached");
    timeoutPend = 1'b1;
    expect_iir(8'hCC, "R4 timeout over rx R2");
    lsrErr = 4'b0100;
    expect_iir(8'hC6, "R3 line error top R2");
    lsrErr = 4'b0000;
    wr_ier(8'h0E);
    expect_iir(8'hC2, "R4 timeout gated by bit0");
    pulse_rd();
    expect_iir(8'hC0, "R8 read clears tx empty");
    wr_ier(8'h0C);
    expect_iir(8'hC0, "R9 bit1 off");
    wr_ier(8'h0E);
    expect_iir(8'hC2, "R9 bit1 on with THRE set");
    pulse_data_wr();
    expect_iir(8'hC0, "R10 data write clears");
    threStat = 1'b0;
    wr_ier(8'h0C); wr_ier(8'h0E);
    expect_iir(8'hC0, "R9 bit1 on with THRE clear");
    pulse_txrst();
    expect_iir(8'hC2, "R10 tx fifo reset sets");
    lsrErr = 4'b0001;
    wr_ier(8'hF0);
    expect_iir(8'hC1, "R11 upper enable bits ignored");
    wr_ier(8'hF4);
    expect_iir(8'hC6, "R11 low nibble taken R3");
    fifoEn = 1'b0;
    expect_iir(8'h06, "R6 fifo bits cleared");
    lsrErr = 4'b1000;
    expect_iir(8'h06, "R3 break flag");
    lsrErr = 4'b0000;
    expect_iir(8'h01, "R7 irq drops with no source");
    modemDelta = 4'b0000; wr_ier(8'h08); modemDelta = 4'b1000;
    expect_iir(8'h00, "R12 other delta bit");

    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule